// File: doc/BRIEF.md
# Signed Narrow Load Extender

This block sits on the write-back side of a single-cycle 32-bit load/store datapath. It receives the current instruction word and the value already picked by the memory-to-register multiplexer. From the instruction's major opcode it works out whether the instruction is a signed halfword load, a signed byte load or anything else. It then passes the word through two chained selectors to produce the value written to the register file.

The first selector either forwards the whole word or sign-extends its low 16 bits. The second selector either forwards what the first produced or sign-extends the low 8 bits of the original word. When the byte path is chosen it wins, whatever the halfword path does. Both narrow paths always use the least significant bits of the word. A word load and every non-load instruction see both selects low, so their value goes through untouched.

The whole path is combinational. Its result is valid within the same cycle as the read data, so write-back timing is unchanged.

Top module: `load_extend_unit`

## Requirements
- R1: An opcode field of 6'b100001 (signed halfword load) drives `half_sel` high and `byte_sel` low.
- R2: An opcode field of 6'b100000 (signed byte load) drives `byte_sel` high and `half_sel` low.
- R3: Every other opcode value drives both `half_sel` and `byte_sel` low.
- R4: The opcode is read from instruction bits 31:26. Bits 25:0 (base register 25:21, destination 20:16, offset 15:0) have no effect on either select or on `wb_data`.
- R5: With `half_sel` high, `wb_data` equals bits 15:0 of `mem_word`, with bit 15 copied into bits 31:16.
- R6: With `byte_sel` high, `wb_data` equals bits 7:0 of `mem_word`, with bit 7 copied into bits 31:8, regardless of the halfword path.
- R7: With both selects low, `wb_data` equals `mem_word` exactly.
- R8: In both narrow modes, the bits of `mem_word` above the kept field have no effect on `wb_data`, for sign bits of either polarity (e.g. 0x00008000 as a halfword gives 0xFFFF8000, 0x00000080 as a byte gives 0xFFFFFF80).
- R9: `wb_data` follows a change of `mem_word` or `instr` without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Current instruction word; the opcode sits in bits 31:26 |
| mem_word | input | 32 | Output of the memory-to-register multiplexer |
| wb_data | output | 32 | Value sent to the register file write port |
| half_sel | output | 1 | Decoded signed halfword load select |
| byte_sel | output | 1 | Decoded signed byte load select |

## Verification
The bench builds the unit with its default 32-bit word, 16-bit halfword, 8-bit byte and 6-bit opcode parameters. These widths keep every case small enough to enumerate. All 64 opcodes are swept under two different fillings of the low instruction bits. Every one of the 65,536 halfword values and all 256 byte values are applied under changing upper bits, with the expected result worked out arithmetically as a signed value. That covers every sign polarity and confirms that the discarded bits never leak into the result.

// File: rtl/lext_pkg.sv
`timescale 1ns/1ps
package lext_pkg;
  // Result path chosen for the current instruction.
  typedef enum logic [1:0] {
    PATH_WORD = 2'd0,
    PATH_HALF = 2'd1,
    PATH_BYTE = 2'd2
  } lext_path_e;

  // Default major opcodes for the two signed narrow loads.
  localparam logic [5:0] OPC_LOAD_HALF = 6'b100001;
  localparam logic [5:0] OPC_LOAD_BYTE = 6'b100000;
endpackage

// File: rtl/lext_decode.sv
`timescale 1ns/1ps
module lext_decode #(
  parameter int              OP_W    = 6,
  parameter logic [OP_W-1:0] OP_HALF = lext_pkg::OPC_LOAD_HALF,
  parameter logic [OP_W-1:0] OP_BYTE = lext_pkg::OPC_LOAD_BYTE
) (
  input  logic [OP_W-1:0] opcode,
  output logic            half_sel,
  output logic            byte_sel
);
  import lext_pkg::*;

  lext_path_e path;

  always_comb begin
    path = PATH_WORD;
    if (opcode == OP_HALF)      path = PATH_HALF;
    else if (opcode == OP_BYTE) path = PATH_BYTE;
  end

  assign half_sel = (path == PATH_HALF);
  assign byte_sel = (path == PATH_BYTE);

  // The decoder never raises both selects together (R1, R2, R3).
  always_comb begin
    if (!$isunknown(opcode)) begin
      assert_sel_onehot_R2: assert ($onehot0({half_sel, byte_sel}))
        else $error("both narrow selects high");
      assert_other_quiet_R3: assert ((opcode == OP_HALF) || (opcode == OP_BYTE) || !(half_sel || byte_sel))
        else $error("select raised for a non-narrow opcode");
    end
  end
endmodule

// File: rtl/lext_narrow_stage.sv
`timescale 1ns/1ps
module lext_narrow_stage #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = 16
) (
  input  logic [DATA_W-1:0] pass_in,
  input  logic [DATA_W-1:0] src_word,
  input  logic              sel,
  output logic [DATA_W-1:0] stage_out
);
  localparam int FILL_W = DATA_W - KEEP_W;

  // Sign-extend the low KEEP_W bits of a word to the full width.
  function automatic logic [DATA_W-1:0] widen_low(input logic [DATA_W-1:0] w);
    return {{FILL_W{w[KEEP_W-1]}}, w[KEEP_W-1:0]};
  endfunction

  logic [DATA_W-1:0] narrow_val;
  assign narrow_val = widen_low(src_word);
  assign stage_out  = sel ? narrow_val : pass_in;

  // Selected: the low field is kept and every upper bit equals its sign (R5, R6).
  // Not selected: the previous value goes through untouched (R7).
  always_comb begin
    if (!$isunknown({sel, src_word, pass_in})) begin
      if (sel) begin
        assert_narrow_sext_R5: assert (stage_out[KEEP_W-1:0] == src_word[KEEP_W-1:0]
            && stage_out[DATA_W-1:KEEP_W] == (src_word[KEEP_W-1] ? {FILL_W{1'b1}} : {FILL_W{1'b0}}))
          else $error("narrow field not sign extended (R5/R6)");
      end else begin
        assert_stage_pass_R7: assert (stage_out == pass_in)
          else $error("unselected stage altered its input");
      end
    end
  end
endmodule

// File: rtl/load_extend_unit.sv
`timescale 1ns/1ps
module load_extend_unit #(
  parameter int                DATA_W  = 32,
  parameter int                HALF_W  = 16,
  parameter int                BYTE_W  = 8,
  parameter int                OP_W    = 6,
  parameter int                OP_LSB  = 26,
  parameter logic [OP_W-1:0]   OP_HALF = lext_pkg::OPC_LOAD_HALF,
  parameter logic [OP_W-1:0]   OP_BYTE = lext_pkg::OPC_LOAD_BYTE
) (
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] wb_data,
  output logic              half_sel,
  output logic              byte_sel
);
  localparam int OP_MSB = OP_LSB + OP_W - 1;

  logic [OP_W-1:0]   opcode;
  logic [DATA_W-1:0] half_stage_out;

  assign opcode = instr[OP_MSB:OP_LSB];

  lext_decode #(
    .OP_W   (OP_W),
    .OP_HALF(OP_HALF),
    .OP_BYTE(OP_BYTE)
  ) u_decode (
    .opcode  (opcode),
    .half_sel(half_sel),
    .byte_sel(byte_sel)
  );

  // First selector: whole word or sign-extended halfword.
  lext_narrow_stage #(
    .DATA_W(DATA_W),
    .KEEP_W(HALF_W)
  ) u_half_stage (
    .pass_in  (mem_word),
    .src_word (mem_word),
    .sel      (half_sel),
    .stage_out(half_stage_out)
  );

  // Second selector: first result or sign-extended byte of the original word.
  lext_narrow_stage #(
    .DATA_W(DATA_W),
    .KEEP_W(BYTE_W)
  ) u_byte_stage (
    .pass_in  (half_stage_out),
    .src_word (mem_word),
    .sel      (byte_sel),
    .stage_out(wb_data)
  );

  always_comb begin
    if (!$isunknown({instr, mem_word})) begin
      assert_half_decode_R1: assert ((opcode != OP_HALF) || (half_sel && !byte_sel))
        else $error("halfword opcode not decoded");
      assert_word_pass_R7: assert (half_sel || byte_sel || (wb_data == mem_word))
        else $error("word path altered the value");
      assert_byte_wins_R6: assert (!byte_sel || (wb_data[BYTE_W-1:0] == mem_word[BYTE_W-1:0]))
        else $error("byte path lost to halfword path");
    end
  end
endmodule

// File: tb/test_load_extend_unit.sv
`timescale 1ns/1ps
module test_load_extend_unit;
  logic        clk = 1'b0;
  logic [31:0] instr;
  logic [31:0] mem_word;
  logic [31:0] wb_data;
  logic        half_sel;
  logic        byte_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  load_extend_unit i_load_extend_unit (
    .instr   (instr),
    .mem_word(mem_word),
    .wb_data (wb_data),
    .half_sel(half_sel),
    .byte_sel(byte_sel)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Signed value of the low n bits, computed arithmetically.
  function automatic logic [31:0] signed_low(input logic [31:0] w, input int n);
    longint v = longint'(w) % (longint'(1) << n);
    if (v >= (longint'(1) << (n - 1))) v = v - (longint'(1) << n);
    return 32'(v);
  endfunction

  task automatic apply(input logic [31:0] i, input logic [31:0] m);
    instr = i; mem_word = m; #1;
  endtask

  initial begin
    apply(32'h0, 32'h0);
    check("R3 reset half_sel", {31'b0, half_sel}, 32'd0);
    check("R3 reset byte_sel", {31'b0, byte_sel}, 32'd0);
    check("R7 reset wb_data", wb_data, 32'h0);

    // Opcode sweep under two fillings of the low instruction bits (R1-R4 each named below).
    for (int op = 0; op < 64; op++) begin
      for (int fill = 0; fill < 2; fill++) begin
        logic [31:0] w = fill ? 32'h1234_5678 : 32'hDEAD_BEEF;
        logic [25:0] low = fill ? 26'h3FF_FFFF : 26'h2AB_CDEF;
        logic [31:0] e;
        apply({6'(op), low}, w);
        e = (op == 33) ? signed_low(w, 16) : (op == 32) ? signed_low(w, 8) : w;
        check(op == 33 ? "R1 half_sel" : "R3 half_sel", {31'b0, half_sel}, {31'b0, op == 33});
        check(op == 32 ? "R2 byte_sel" : "R3 byte_sel", {31'b0, byte_sel}, {31'b0, op == 32});
        check("R4 wb_data under opcode sweep", wb_data, e);
      end
    end

    // Exhaustive halfword sweep with varying upper bits (R5, R8).
    for (int v = 0; v < 65536; v++) begin
      logic [31:0] up = 32'((v * 40503) & 16'hFFFF);
      apply({6'b100001, 26'(v * 7)}, {up[15:0], 16'(v)});
      check("R5 halfword sext", wb_data, signed_low(32'(v), 16));
    end

    // Exhaustive byte sweep with varying upper bits (R6, R8).
    for (int v = 0; v < 256; v++) begin
      for (int u = 0; u < 4; u++) begin
        logic [23:0] up = 24'(u * 24'h5A_C3F1 + v * 24'h01_0203);
        apply({6'b100000, 26'(v + u)}, {up, 8'(v)});
        check("R6 byte sext", wb_data, signed_low(32'(v), 8));
      end
    end

    // Sign-polarity corners with upper bits set or cleared (R8).
    apply({6'b100001, 26'h0}, 32'h0000_8000); check("R8 half neg", wb_data, 32'hFFFF_8000);
    apply({6'b100001, 26'h0}, 32'hFFFF_7FFF); check("R8 half pos", wb_data, 32'h0000_7FFF);
    apply({6'b100000, 26'h0}, 32'h0000_0080); check("R8 byte neg", wb_data, 32'hFFFF_FF80);
    apply({6'b100000, 26'h0}, 32'hFFFF_FF7F); check("R8 byte pos", wb_data, 32'h0000_007F);
    apply({6'b100011, 26'h0}, 32'h8000_8080); check("R7 word load", wb_data, 32'h8000_8080);

    // Combinational follow-through within one half clock period (R9).
    @(negedge clk);
    instr = {6'b100000, 26'h0}; mem_word = 32'h0000_00F0;
    #1; check("R9 same cycle byte", wb_data, 32'hFFFF_FFF0);
    mem_word = 32'h0000_0010;
    #1; check("R9 same cycle update", wb_data, 32'h0000_0010);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule